// File: doc/BRIEF.md
# SDRAM Power-Up State Sequencer

This block brings an SDRAM controller out of reset and into normal operation. Software walks it through a fixed chain of states by writing a refresh-control register: clock-stopped self-refresh, then self-refresh, then power-down, then power-down exit, and from there the sequencer settles in NOP by itself. Each step needs its own write, and a write that asks for a step the current state does not allow has no effect on the state.

Once the sequencer is in NOP, software programs a configuration register that holds a two-bit enable field for each partition pair and a shared two-bit timing code. Dummy accesses aimed at a pair with both partitions disabled become all-bank CBR refresh commands. The first such access after reset is preceded by a precharge-all. A write to the mode-set register issues one MRS command to each enabled pair, lowest pair first. A refresh-interval down-counter then raises a one-cycle refresh request at a fixed period.

The command bus is modelled at cycle level: clock enable, one chip select per pair, RAS, CAS, WE and the address bus. The current state is also driven out on a status port.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is 0 (clock-stopped self-refresh), CKE is low, every chip select is high, RAS/CAS/WE are high, the address is 0 and no refresh request is raised.
- R2: A refresh-control write (wr_sel 0) with a non-zero interval in bits 11:0 and the clock-run bit (bit 12) set moves state 0 to state 1 (self-refresh). A refresh-control write whose interval is zero is ignored completely.
- R3: In state 1, a valid refresh-control write with bit 13 set moves to state 2 (power-down). In state 2, a valid write with bit 14 set moves to state 3 (power-down exit). A bit that belongs to another state is ignored, so one write advances the state by at most one step.
- R4: State 3 moves to state 4 (NOP) on the next clock with no write.
- R5: CKE is low in states 0 to 2 and high from state 3 onward. In states 0 to 2 all chip selects are high. In states 3, 4 and 8 (wait) all chip selects are low and the command is NOP (RAS, CAS, WE = 1,1,1).
- R6: The first dummy access after reset (acc_req in NOP, aimed at a pair whose enable field is 00) gives, in order: one precharge-all cycle (state 5, RAS=0 CAS=1 WE=0, address bit 10 high), tRP-1 wait cycles, one auto-refresh cycle (state 6, RAS=0 CAS=0 WE=1, all chip selects low), tRC-1 wait cycles, and then NOP.
- R7: Each later dummy access to a disabled pair goes straight to auto-refresh followed by tRC-1 wait cycles.
- R8: Dummy accesses are ignored when the target pair has either enable bit set, when the state is not NOP, or when a register write occurs in the same cycle.
- R9: A mode-set write (wr_sel 2) in NOP issues one MRS cycle (state 7, RAS=CAS=WE=0) per enabled pair, in ascending pair order. Only that pair's chip select is low. Each MRS is followed by one wait cycle. The address carries burst length code 010 in bits 2:0, sequential type (bit 3 = 0) and CAS latency in bits 6:4. With no pair enabled the write is ignored.
- R10: The timing code sits in configuration bits [8*NPAIR+1 : 8*NPAIR]. CAS latency is 3 for codes 2 and 3 and 2 otherwise. tRP = code+1 and tRC = 3*code+4, so code 2 gives tRP 3, CL 3 and tRC 10.
- R11: The configuration register (wr_sel 1) gives pair p the byte [8p+7:8p], with the enable bits at 1:0 of that byte. The other byte bits describe geometry and do not affect commands. Configuration writes outside NOP are ignored.
- R12: In states 4 and above with at least one enable bit set, ref_tick pulses once every interval cycles, counted from the first such cycle. In any other state, or with no pair enabled, it stays low.
- R13: A write with wr_sel 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 refresh control, 1 configuration, 2 mode set |
| wr_data | input | DATA_W | Write data |
| acc_req | input | 1 | Single non-burst dummy access request |
| acc_pair | input | PAIR_W | Partition pair targeted by the access |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | NPAIR | Chip select per partition pair, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Command address bus |
| ref_tick | output | 1 | Periodic refresh request pulse |
| seq_state | output | 4 | Current sequencer state code |

## Verification
The bench uses the default build of two partition pairs and a 13-bit address. With two pairs it can check that MRS commands come out in ascending pair order and that each MRS asserts only its own chip select. It can also check accesses to an enabled pair next to accesses to a disabled one. A refresh interval of 5 produces several refresh pulses in a short run. All four timing codes are driven, including code 0, where tRP is a single cycle and precharge-all is followed directly by refresh. A second reset in the middle of the run confirms that the precharge-all happens again on the first access after each reset.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_CLKSTOP = 4'd0,
        ST_SELFREF = 4'd1,
        ST_PWRDN   = 4'd2,
        ST_PDX     = 4'd3,
        ST_NOP     = 4'd4,
        ST_PALL    = 4'd5,
        ST_CBR     = 4'd6,
        ST_MRS     = 4'd7,
        ST_WAIT    = 4'd8
    } seq_state_e;

    localparam logic [1:0] SEL_REFCTL  = 2'd0;
    localparam logic [1:0] SEL_CONFIG  = 2'd1;
    localparam logic [1:0] SEL_MODESET = 2'd2;

    // refresh-control step bits, above the 12-bit interval field
    localparam int RUN_BIT = 12;
    localparam int SRX_BIT = 13;
    localparam int CKE_BIT = 14;

    localparam logic [3:0] MRD_CYC = 4'd2;

    function automatic logic [2:0] cas_lat(input logic [1:0] tc);
        return tc[1] ? 3'd3 : 3'd2;
    endfunction

    function automatic logic [3:0] t_rp(input logic [1:0] tc);
        return {2'b00, tc} + 4'd1;
    endfunction

    function automatic logic [3:0] t_rc(input logic [1:0] tc);
        return 4'd4 + {2'b00, tc} + {2'b00, tc} + {2'b00, tc};
    endfunction

endpackage

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
    import sdr_seq_pkg::*;
#(
    parameter int NPAIR  = 2,
    parameter int IVAL_W = 12,
    parameter int DATA_W = 32,
    localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              acc_req,
    input  logic [PAIR_W-1:0] acc_pair,
    output seq_state_e        state_o,
    output logic [PAIR_W-1:0] pair_o,
    output logic [1:0]        tc_o,
    output logic [IVAL_W-1:0] ival_o,
    output logic              run_o
);

    localparam int TC_LSB = 8 * NPAIR;

    typedef struct packed {
        seq_state_e               st;
        seq_state_e               after;
        logic [3:0]               cnt;
        logic [PAIR_W-1:0]        pair;
        logic                     first;
        logic [IVAL_W-1:0]        ival;
        logic [NPAIR-1:0][1:0]    en;
        logic [1:0]               tc;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st: ST_CLKSTOP, after: ST_NOP, cnt: '0, pair: '0,
        first: 1'b0, ival: '0, en: '0, tc: '0
    };

    fsm_t q, d;

    logic [PAIR_W-1:0] first_p, next_p;
    logic              next_ok, acc_hit, any_en;
    logic              is_ref, is_cfg, is_mrs;
    logic [IVAL_W-1:0] ival_f;
    logic              unused_wr;

    assign unused_wr = ^wr_data;
    assign is_ref    = wr_en && (wr_sel == SEL_REFCTL);
    assign is_cfg    = wr_en && (wr_sel == SEL_CONFIG);
    assign is_mrs    = wr_en && (wr_sel == SEL_MODESET);
    assign ival_f    = wr_data[IVAL_W-1:0];
    assign any_en    = |q.en;

    function automatic fsm_t go_to(fsm_t s, logic [3:0] len, seq_state_e tgt);
        fsm_t r;
        r = s;
        if (len <= 4'd1) begin
            r.st = tgt;
        end else begin
            r.st    = ST_WAIT;
            r.cnt   = len - 4'd2;
            r.after = tgt;
        end
        return r;
    endfunction

    // pair search: lowest enabled, next enabled above current, access target
    always_comb begin
        first_p = '0;
        next_p  = '0;
        next_ok = 1'b0;
        acc_hit = 1'b0;
        for (int p = NPAIR - 1; p >= 0; p--) begin
            if (|q.en[p]) first_p = PAIR_W'(p);
            if ((|q.en[p]) && (PAIR_W'(p) > q.pair)) begin
                next_p  = PAIR_W'(p);
                next_ok = 1'b1;
            end
            if ((acc_pair == PAIR_W'(p)) && !(|q.en[p])) acc_hit = 1'b1;
        end
    end

    always_comb begin
        d = q;
        if (is_ref && (ival_f != '0)) begin
            d.ival = ival_f;
            case (q.st)
                ST_CLKSTOP: if (wr_data[RUN_BIT]) d.st = ST_SELFREF;
                ST_SELFREF: if (wr_data[SRX_BIT]) d.st = ST_PWRDN;
                ST_PWRDN:   if (wr_data[CKE_BIT]) d.st = ST_PDX;
                default: ;
            endcase
        end
        case (q.st)
            ST_PDX: d.st = ST_NOP;
            ST_NOP: begin
                if (is_cfg) begin
                    for (int p = 0; p < NPAIR; p++) d.en[p] = wr_data[8*p +: 2];
                    d.tc = wr_data[TC_LSB +: 2];
                end else if (is_mrs) begin
                    if (any_en) begin
                        d.pair = first_p;
                        d.st   = ST_MRS;
                    end
                end else if (!wr_en && acc_req && acc_hit) begin
                    if (!q.first) begin
                        d.first = 1'b1;
                        d.st    = ST_PALL;
                    end else begin
                        d.st = ST_CBR;
                    end
                end
            end
            ST_PALL: d = go_to(d, t_rp(q.tc), ST_CBR);
            ST_CBR:  d = go_to(d, t_rc(q.tc), ST_NOP);
            ST_MRS: begin
                if (next_ok) begin
                    d.pair = next_p;
                    d = go_to(d, MRD_CYC, ST_MRS);
                end else begin
                    d = go_to(d, MRD_CYC, ST_NOP);
                end
            end
            ST_WAIT: begin
                if (q.cnt == '0) d.st = q.after;
                else             d.cnt = q.cnt - 4'd1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign state_o = q.st;
    assign pair_o  = q.pair;
    assign tc_o    = q.tc;
    assign ival_o  = q.ival;
    assign run_o   = (q.st >= ST_NOP) && any_en;

endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
    import sdr_seq_pkg::*;
#(
    parameter int NPAIR  = 2,
    parameter int ADDR_W = 13,
    localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  seq_state_e        st,
    input  logic [PAIR_W-1:0] pair,
    input  logic [1:0]        tc,
    output logic              cke,
    output logic [NPAIR-1:0]  cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        cke   = 1'b1;
        cs_n  = '0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        case (st)
            ST_CLKSTOP, ST_SELFREF, ST_PWRDN: begin
                cke  = 1'b0;
                cs_n = '1;
            end
            ST_PALL: begin
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            ST_CBR: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            ST_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                for (int p = 0; p < NPAIR; p++) cs_n[p] = (pair != PAIR_W'(p));
                addr[6:4] = cas_lat(tc);
                addr[3]   = 1'b0;
                addr[2:0] = 3'b010;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int IVAL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IVAL_W-1:0] ival,
    output logic              tick
);

    logic [IVAL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = ival;
        end else if (cnt_q <= IVAL_W'(1)) begin
            tick  = 1'b1;
            cnt_d = ival;
        end else begin
            cnt_d = cnt_q - IVAL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdr_seq_pkg::*;
#(
    parameter int NPAIR  = 2,
    parameter int ADDR_W = 13,
    parameter int IVAL_W = 12,
    parameter int DATA_W = 32,
    localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              acc_req,
    input  logic [PAIR_W-1:0] acc_pair,
    output logic              sd_cke,
    output logic [NPAIR-1:0]  sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              ref_tick,
    output logic [3:0]        seq_state
);

    seq_state_e        st_w;
    logic [PAIR_W-1:0] pair_w;
    logic [1:0]        tc_w;
    logic [IVAL_W-1:0] ival_w;
    logic              run_w;

    sdr_seq_fsm #(.NPAIR(NPAIR), .IVAL_W(IVAL_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_req(acc_req), .acc_pair(acc_pair),
        .state_o(st_w), .pair_o(pair_w), .tc_o(tc_w), .ival_o(ival_w),
        .run_o(run_w)
    );

    sdr_cmd_enc #(.NPAIR(NPAIR), .ADDR_W(ADDR_W)) u_enc (
        .st(st_w), .pair(pair_w), .tc(tc_w), .cke(sd_cke), .cs_n(sd_cs_n),
        .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr)
    );

    sdr_ref_timer #(.IVAL_W(IVAL_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run_w), .ival(ival_w), .tick(ref_tick)
    );

    assign seq_state = st_w;

endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk
    import sdr_seq_pkg::*;
#(
    parameter int NPAIR  = 2,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        state,
    input logic              cke,
    input logic [NPAIR-1:0]  cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              tick
);

    a_r2_leave_clkstop_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLKSTOP) |=> (state == ST_CLKSTOP || state == ST_SELFREF));

    a_r3_selfref_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELFREF) |=> (state == ST_SELFREF || state == ST_PWRDN));

    a_r3_pwrdn_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRDN) |=> (state == ST_PWRDN || state == ST_PDX));

    a_r4_exit_to_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDX) |=> (state == ST_NOP));

    a_r5_cke_low_early: assert property (@(posedge clk) disable iff (!rst_n)
        (state <= ST_PWRDN) |-> (!cke && cs_n == '1));

    a_r5_cke_high_late: assert property (@(posedge clk) disable iff (!rst_n)
        (state >= ST_PDX) |-> cke);

    a_r6_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n && !we_n) |-> (addr[10] && cs_n == '0));

    a_r8_no_cmd_during_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (state <= ST_PDX) |=> (state <= ST_NOP));

    a_r9_mrs_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && !we_n) |-> ($countones(~cs_n) == 1 && addr[3:0] == 4'b0010));

    a_r12_tick_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (state <= ST_PDX) |-> !tick);

endmodule

bind sdram_pwrup_seq sdr_seq_chk #(.NPAIR(NPAIR), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(seq_state), .cke(sd_cke), .cs_n(sd_cs_n),
    .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr),
    .tick(ref_tick)
);

// File: tb/tb_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module tb_sdram_pwrup_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        acc_req = 1'b0;
    logic [0:0]  acc_pair = 1'b0;
    logic        sd_cke, sd_ras_n, sd_cas_n, sd_we_n, ref_tick;
    logic [1:0]  sd_cs_n;
    logic [12:0] sd_addr;
    logic [3:0]  seq_state;

    always #2 clk = ~clk;

    sdram_pwrup_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_req(acc_req), .acc_pair(acc_pair), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .ref_tick(ref_tick), .seq_state(seq_state)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // behavioural reference: expected per-cycle entries {state,cke,ras,cas,we,cs_n,addr}
    logic [22:0] exq[$];
    logic [22:0] m_cur;
    int          m_phase, m_ival, m_since;
    bit          m_first, m_tick;
    logic [1:0]  m_en0, m_en1, m_tc;

    localparam int RUN = 1 << 12;
    localparam int SRX = 1 << 13;
    localparam int CKB = 1 << 14;

    function automatic logic [22:0] ent(int st, bit ck, logic [2:0] cmd, logic [1:0] cs, int a);
        return {4'(st), ck, cmd, cs, 13'(a)};
    endfunction

    function automatic logic [22:0] phase_ent(int ph);
        if (ph < 3) return ent(ph, 0, 3'b111, 2'b11, 0);
        if (ph == 3) return ent(3, 1, 3'b111, 2'b00, 0);
        return ent(4, 1, 3'b111, 2'b00, 0);
    endfunction

    task automatic model_reset();
        exq.delete();
        m_phase = 0; m_ival = 0; m_since = 0; m_first = 0; m_tick = 0;
        m_en0 = 0; m_en1 = 0; m_tc = 0;
        m_cur = phase_ent(0);
    endtask

    task automatic push_waits(int n);
        for (int i = 0; i < n; i++) exq.push_back(ent(8, 1, 3'b111, 2'b00, 0));
    endtask

    task automatic model_step(bit we, logic [1:0] sel, logic [31:0] dat, bit acc, bit pr);
        int  nph = m_phase;
        bit  nop_now = (m_cur[22:19] == 4'd4);
        int  cl = (m_tc >= 2) ? 3 : 2;
        int  rp = m_tc + 1;
        int  rc = 3 * m_tc + 4;
        bit  dis;
        if (we && sel == 2'd0 && dat[11:0] != 0) begin
            m_ival = dat[11:0];
            if (m_phase == 0 && dat[12]) nph = 1;
            else if (m_phase == 1 && dat[13]) nph = 2;
            else if (m_phase == 2 && dat[14]) nph = 3;
        end
        if (m_phase == 3) nph = 4;
        if (nop_now) begin
            dis = pr ? (m_en1 == 0) : (m_en0 == 0);
            if (we && sel == 2'd1) begin
                m_en0 = dat[1:0]; m_en1 = dat[9:8]; m_tc = dat[17:16];
            end else if (we && sel == 2'd2) begin
                if (m_en0 != 0) begin exq.push_back(ent(7, 1, 3'b000, 2'b10, (cl << 4) | 2)); push_waits(1); end
                if (m_en1 != 0) begin exq.push_back(ent(7, 1, 3'b000, 2'b01, (cl << 4) | 2)); push_waits(1); end
            end else if (!we && acc && dis) begin
                if (!m_first) begin
                    exq.push_back(ent(5, 1, 3'b010, 2'b00, 13'h400));
                    push_waits(rp - 1);
                    m_first = 1;
                end
                exq.push_back(ent(6, 1, 3'b001, 2'b00, 0));
                push_waits(rc - 1);
            end
        end
        m_phase = nph;
        if (m_phase < 4) m_cur = phase_ent(m_phase);
        else if (exq.size() > 0) m_cur = exq.pop_front();
        else m_cur = phase_ent(4);
        if (m_cur[22:19] >= 4'd4 && (m_en0 != 0 || m_en1 != 0)) begin
            m_tick = (((m_since + 1) % m_ival) == 0);
            m_since++;
        end else begin
            m_tick = 0;
            m_since = 0;
        end
    endtask

    task automatic compare();
        logic [22:0] act;
        act = {seq_state, sd_cke, sd_ras_n, sd_cas_n, sd_we_n, sd_cs_n, sd_addr};
        n_checks++;
        if (act !== m_cur || ref_tick !== m_tick) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h/%b expected=%h/%b", cur_req, $time, act, ref_tick, m_cur, m_tick);
        end
    endtask

    task automatic cyc(bit we, logic [1:0] sel, logic [31:0] dat, bit acc, bit pr);
        wr_en = we; wr_sel = sel; wr_data = dat; acc_req = acc; acc_pair = pr;
        @(posedge clk);
        model_step(we, sel, dat, acc, pr);
        @(negedge clk);
        compare();
        wr_en = 0; acc_req = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 32'h0, 0, 0);
    endtask

    task automatic do_reset();
        cur_req = "R1";
        @(negedge clk);
        rst_n = 0;
        wr_en = 0; acc_req = 0;
        repeat (3) @(negedge clk);
        model_reset();
        compare();
        rst_n = 1;
        idle(2);
    endtask

    task automatic power_up();
        cur_req = "R2";
        cyc(1, 2'd0, RUN, 0, 0);                        // zero interval: ignored
        cyc(1, 2'd0, RUN | SRX | CKB | 5, 0, 0);        // one step only
        cur_req = "R5";
        idle(2);
        cur_req = "R3";
        cyc(1, 2'd0, CKB | 5, 0, 0);                    // wrong bit for state 1
        cyc(1, 2'd0, SRX | 5, 0, 0);
        idle(1);
        cyc(1, 2'd0, CKB | 5, 0, 0);
        cur_req = "R4";
        idle(2);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        cur_req = "R8";  cyc(0, 2'd0, 0, 1, 0);            // access during power-up
        cur_req = "R11"; cyc(1, 2'd1, 32'h0002_0301, 0, 0); // config outside NOP
        power_up();

        cur_req = "R10"; cyc(1, 2'd1, 32'h0000_FCFC, 0, 0);  // code 0, no enables
        cur_req = "R6";  cyc(0, 2'd0, 0, 1, 0);              // PALL then CBR (tRP 1)
        cur_req = "R8";  cyc(0, 2'd0, 0, 1, 1);              // busy: ignored
        cur_req = "R11"; cyc(1, 2'd1, 32'h0002_0101, 0, 0);  // busy: ignored
        idle(4);
        cur_req = "R7";  cyc(0, 2'd0, 0, 1, 1);
        idle(4);
        cur_req = "R8";  cyc(1, 2'd0, 32'h5, 1, 0);          // write same cycle wins
        idle(1);
        cur_req = "R9";  cyc(1, 2'd2, 32'hFFFF_FFFF, 0, 0);  // nothing enabled
        idle(1);
        cur_req = "R11"; cyc(1, 2'd1, 32'h0002_A239, 0, 0);  // pair0 01, pair1 10, code 2
        cur_req = "R9";  cyc(1, 2'd2, 32'h0, 0, 0);
        idle(5);
        cur_req = "R8";  cyc(0, 2'd0, 0, 1, 0);
        cyc(0, 2'd0, 0, 1, 1);
        cur_req = "R12"; idle(12);
        cur_req = "R13"; cyc(1, 2'd3, 32'hFFFF_FFFF, 0, 0);
        idle(2);
        cur_req = "R11"; cyc(1, 2'd1, 32'h0002_0100, 0, 0);  // only pair1 enabled
        cur_req = "R7";  cyc(0, 2'd0, 0, 1, 0);              // tRC 10
        idle(11);
        cur_req = "R8";  cyc(0, 2'd0, 0, 1, 1);
        cur_req = "R9";  cyc(1, 2'd2, 32'h0, 0, 0);
        idle(3);
        cur_req = "R12"; cyc(1, 2'd1, 32'h0002_0000, 0, 0);  // all disabled: no ticks
        idle(7);

        do_reset();
        power_up();
        cur_req = "R10"; cyc(1, 2'd1, 32'h0002_0000, 0, 0);  // code 2: tRP 3, tRC 10
        cur_req = "R6";  cyc(0, 2'd0, 0, 1, 0);
        idle(15);
        cur_req = "R10"; cyc(1, 2'd1, 32'h0003_0000, 0, 0);  // code 3: tRC 13
        cur_req = "R7";  cyc(0, 2'd0, 0, 1, 1);
        idle(15);
        cur_req = "R10"; cyc(1, 2'd1, 32'h0003_0001, 0, 0);
        cur_req = "R9";  cyc(1, 2'd2, 32'h0, 0, 0);
        idle(3);
        cur_req = "R10"; cyc(1, 2'd1, 32'h0001_0002, 0, 0);  // code 1: CL 2
        cur_req = "R9";  cyc(1, 2'd2, 32'h0, 0, 0);
        cur_req = "R12"; idle(8);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule